// File: doc/BRIEF.md
# Compact Prioritised Interrupt Controller

This block gathers up to 32 external interrupt request lines and one non-maskable line for a small microcontroller core. Each external line has an enable bit, a pending bit and a priority. Only two priority bits are kept for each line, which gives four levels. A rising edge on a line records the request as pending. The controller then picks one pending, enabled line and offers its number to the core on a valid/ready style channel. The core takes the offered interrupt by asserting the acknowledge, which clears that line's pending bit.

Software reaches the controller through a plain 32-bit register port: byte address, write and read strobes, byte write strobes, write data, read data, and an error flag. Both read data and the error flag are combinational from the address in the same cycle. Several registers that larger controllers implement are reserved here:
- the type word reports an error;
- the active-bit window always reads zero;
- the application control word returns only its fixed key, and any write to it is discarded.

On the interrupt channel, `irq_valid` is raised while any enabled line is pending. The core may hold `irq_ack` low for as long as it likes, and the request then stays pending. Until the handshake completes, `irq_id` follows the current best candidate, so a more urgent arrival replaces the number on offer. The handshake completes in a cycle where `irq_valid` and `irq_ack` are both high, and it retires the number shown in that cycle.

Top module: `small_intc`

## Requirements
- R1: After reset, every enable bit, pending bit and priority field is zero, and both `irq_valid` and `nmi_valid` are low.
- R2: A 0-to-1 transition on `irq_lines[n]` sets pending bit n at the next clock. A line held high does not set the bit again after it has been cleared.
- R3: Writing a word with bit n at 1 to set-enable (0x100) or set-pending (0x200) sets bit n. Writing it to clear-enable (0x180) or clear-pending (0x280) clears bit n. Zero bits leave their state unchanged. Reading either address of a pair returns the current bank.
- R4: The priority of line n lives in byte (n mod 4) of the word at 0x400 + 4*(n/4), and only the bytes selected by `bus_wstrb` are written. Only byte bits [7:6] are stored, and bits [5:0] read as zero.
- R5: `irq_valid` is high exactly when some line is both enabled and pending. `irq_id` is the line with the lowest stored priority value, and the lowest line number wins a tie.
- R6: Any register write or edge that changes the selection shows on `irq_id`/`irq_valid` in the cycle right after the clock edge that stored it.
- R7: A cycle with `irq_valid` and `irq_ack` both high clears the pending bit of the `irq_id` shown in that cycle.
- R8: An access to the type word at 0x004 raises `bus_err` and reads zero. Every other address gives `bus_err` low.
- R9: Reads anywhere in 0x300–0x33F return zero, whatever the enable and pending state.
- R10: The control word at 0xD0C reads 0xFA050000. Writes to it change no readable state and no output. The internal group setting stays at 5 and is never returned.
- R11: A rising edge on `nmi_req` raises `nmi_valid` at the next clock, and no register setting can block it. `nmi_ack` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 12 | Byte address within the control space |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wstrb | input | 4 | Byte write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| bus_err | output | 1 | Reserved-register error flag |
| irq_lines | input | 32 | External interrupt request lines |
| irq_valid | output | 1 | An interrupt is on offer |
| irq_id | output | 5 | Number of the offered line |
| irq_ack | input | 1 | Core takes the offered interrupt |
| nmi_req | input | 1 | Non-maskable request line |
| nmi_valid | output | 1 | Non-maskable interrupt pending |
| nmi_ack | input | 1 | Core takes the non-maskable interrupt |

## Verification
The hardest situation to reach from the ports is a mix of several lines that are pending at once with different enable states and truncated priorities. In that mix, the winner moves only because of a tie, an acknowledge or a cleared enable. The stimulus gets there in steps:
- it writes priority bytes whose low six bits are set, so truncation decides the order;
- it enables a subset of lines and leaves one line pending but disabled;
- it then retires winners one at a time, through the acknowledge and the clear registers, and checks the next candidate after each step.

A line held high across a clear-pending write is also needed, to show that a level does not re-arm the pending bit.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_TYPE     = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_SETEN    = 12'h100;
  localparam logic [ADDR_W-1:0] OFF_CLREN    = 12'h180;
  localparam logic [ADDR_W-1:0] OFF_SETPEND  = 12'h200;
  localparam logic [ADDR_W-1:0] OFF_CLRPEND  = 12'h280;
  localparam logic [ADDR_W-1:0] OFF_ACT_LO   = 12'h300;
  localparam logic [ADDR_W-1:0] OFF_ACT_HI   = 12'h33C;
  localparam logic [ADDR_W-1:0] OFF_PRIO     = 12'h400;
  localparam logic [ADDR_W-1:0] OFF_CTRL     = 12'hD0C;

  localparam logic [15:0] CTRL_KEY     = 16'hFA05;
  localparam logic [2:0]  GROUP_FIXED  = 3'd5;

  typedef enum logic [3:0] {
    RG_NONE, RG_TYPE, RG_SETEN, RG_CLREN, RG_SETPEND,
    RG_CLRPEND, RG_ACTIVE, RG_PRIO, RG_CTRL
  } reg_sel_e;
endpackage

// File: rtl/intc_pend_bank.sv
module intc_pend_bank #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] set_mask,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] pend
);
  logic [N-1:0] prev_q;
  logic [N-1:0] rise;

  assign rise = lines & ~prev_q;

  // set sources win over clear sources in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend   <= '0;
    end else begin
      prev_q <= lines;
      pend   <= (pend & ~clr_mask) | set_mask | rise;
    end
  end
endmodule

// File: rtl/intc_prio_store.sv
module intc_prio_store #(
  parameter int unsigned N      = 32,
  parameter int unsigned PRIO_W = 2,
  localparam int unsigned WORDS = (N + 3) / 4,
  localparam int unsigned WI_W  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [WI_W-1:0]     word_idx,
  input  logic [3:0]          wstrb,
  input  logic [31:0]         wdata,
  output logic [N*PRIO_W-1:0] prio
);
  for (genvar n = 0; n < N; n++) begin : g_line
    localparam int unsigned BYTE = n % 4;
    localparam int unsigned WORD = n / 4;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        prio[n*PRIO_W +: PRIO_W] <= '0;
      else if (wr && (word_idx == WI_W'(WORD)) && wstrb[BYTE])
        prio[n*PRIO_W +: PRIO_W] <= wdata[8*BYTE+7 -: PRIO_W];
    end
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int unsigned N      = 32,
  parameter int unsigned PRIO_W = 2,
  localparam int unsigned ID_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]        cand,
  input  logic [N*PRIO_W-1:0] prio,
  output logic                valid,
  output logic [ID_W-1:0]     id
);
  logic [PRIO_W-1:0] best;

  // ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    valid = 1'b0;
    id    = '0;
    best  = '1;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!valid || (prio[i*PRIO_W +: PRIO_W] < best))) begin
        valid = 1'b1;
        id    = ID_W'(i);
        best  = prio[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/small_intc.sv
module small_intc
  import intc_pkg::*;
#(
  parameter int unsigned N_IRQ  = 32,
  parameter int unsigned PRIO_W = 2,
  localparam int unsigned ID_W  = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
  localparam int unsigned WORDS = (N_IRQ + 3) / 4,
  localparam int unsigned WI_W  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_wstrb,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  input  logic [N_IRQ-1:0]  irq_lines,
  output logic              irq_valid,
  output logic [ID_W-1:0]   irq_id,
  input  logic              irq_ack,
  input  logic              nmi_req,
  output logic              nmi_valid,
  input  logic              nmi_ack
);
  localparam logic [9:0] W_PRIO = OFF_PRIO[11:2];

  reg_sel_e               sel;
  logic [9:0]             wa;
  logic [9:0]             prio_off;
  logic [N_IRQ-1:0]       en_q;
  logic [N_IRQ-1:0]       pend_q;
  logic [N_IRQ-1:0]       set_pend, clr_pend, ack_mask;
  logic [N_IRQ*PRIO_W-1:0] prio_flat;
  logic [31:0]            bank_word;

  assign wa       = bus_addr[11:2];
  assign prio_off = wa - W_PRIO;

  // register decode; the active window and the type word are reserved
  always_comb begin
    sel = RG_NONE;
    if      (wa == OFF_TYPE[11:2])                          sel = RG_TYPE;
    else if (wa == OFF_SETEN[11:2])                         sel = RG_SETEN;
    else if (wa == OFF_CLREN[11:2])                         sel = RG_CLREN;
    else if (wa == OFF_SETPEND[11:2])                       sel = RG_SETPEND;
    else if (wa == OFF_CLRPEND[11:2])                       sel = RG_CLRPEND;
    else if (wa >= OFF_ACT_LO[11:2] && wa <= OFF_ACT_HI[11:2]) sel = RG_ACTIVE;
    else if (wa >= W_PRIO && wa < W_PRIO + 10'(WORDS))      sel = RG_PRIO;
    else if (wa == OFF_CTRL[11:2])                          sel = RG_CTRL;
  end

  // enable bank
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      en_q <= '0;
    else if (bus_wr && sel == RG_SETEN)
      en_q <= en_q | bus_wdata[N_IRQ-1:0];
    else if (bus_wr && sel == RG_CLREN)
      en_q <= en_q & ~bus_wdata[N_IRQ-1:0];
  end

  // pending bank sources
  always_comb begin
    set_pend = (bus_wr && sel == RG_SETPEND) ? bus_wdata[N_IRQ-1:0] : '0;
    ack_mask = '0;
    if (irq_valid && irq_ack) ack_mask[irq_id] = 1'b1;
    clr_pend = ack_mask |
               ((bus_wr && sel == RG_CLRPEND) ? bus_wdata[N_IRQ-1:0] : '0);
  end

  intc_pend_bank #(.N(N_IRQ)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines    (irq_lines),
    .set_mask (set_pend),
    .clr_mask (clr_pend),
    .pend     (pend_q)
  );

  intc_pend_bank #(.N(1)) u_nmi (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines    (nmi_req),
    .set_mask (1'b0),
    .clr_mask (nmi_ack),
    .pend     (nmi_valid)
  );

  intc_prio_store #(.N(N_IRQ), .PRIO_W(PRIO_W)) u_prio (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (bus_wr && sel == RG_PRIO),
    .word_idx (prio_off[WI_W-1:0]),
    .wstrb    (bus_wstrb),
    .wdata    (bus_wdata),
    .prio     (prio_flat)
  );

  intc_arbiter #(.N(N_IRQ), .PRIO_W(PRIO_W)) u_arb (
    .cand  (en_q & pend_q),
    .prio  (prio_flat),
    .valid (irq_valid),
    .id    (irq_id)
  );

  // read path; the fixed group setting is deliberately not returned
  always_comb begin
    bank_word = '0;
    bus_rdata = '0;
    case (sel)
      RG_SETEN, RG_CLREN: begin
        bank_word[N_IRQ-1:0] = en_q;
        bus_rdata = bank_word;
      end
      RG_SETPEND, RG_CLRPEND: begin
        bank_word[N_IRQ-1:0] = pend_q;
        bus_rdata = bank_word;
      end
      RG_PRIO: begin
        for (int n = 0; n < N_IRQ; n++)
          if (prio_off == 10'(n / 4))
            bus_rdata[8*(n%4)+7 -: PRIO_W] = prio_flat[n*PRIO_W +: PRIO_W];
      end
      RG_CTRL:  bus_rdata = {CTRL_KEY, 16'h0000};
      default:  bus_rdata = '0;
    endcase
  end

  assign bus_err = (bus_wr || bus_rd) && (sel == RG_TYPE);
endmodule

// File: rtl/small_intc_chk.sv
module small_intc_chk #(
  parameter int unsigned N_IRQ = 32,
  parameter int unsigned ID_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [11:0]      bus_addr,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [31:0]      bus_rdata,
  input logic             bus_err,
  input logic [N_IRQ-1:0] en_q,
  input logic [N_IRQ-1:0] pend_q,
  input logic             irq_valid,
  input logic [ID_W-1:0]  irq_id,
  input logic             nmi_req,
  input logic             nmi_valid
);
  a_r5_winner_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (en_q[irq_id] && pend_q[irq_id]));

  a_r5_no_idle_candidate: assert property (@(posedge clk) disable iff (!rst_n)
    (|(en_q & pend_q)) |-> irq_valid);

  a_r3_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(en_q));

  a_r8_type_error: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[11:2] == 10'h001) |-> (bus_err && bus_rdata == 32'h0));

  a_r9_active_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr >= 12'h300 && bus_addr <= 12'h33F) |-> bus_rdata == 32'h0);

  a_r10_ctrl_key: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[11:2] == 10'h343) |-> bus_rdata == 32'hFA05_0000);

  a_r11_nmi_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_req) |=> nmi_valid);
endmodule

bind small_intc small_intc_chk #(.N_IRQ(N_IRQ), .ID_W(ID_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .bus_err   (bus_err),
  .en_q      (en_q),
  .pend_q    (pend_q),
  .irq_valid (irq_valid),
  .irq_id    (irq_id),
  .nmi_req   (nmi_req),
  .nmi_valid (nmi_valid)
);

// File: tb/test_small_intc.sv
module test_small_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_wstrb = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [31:0] irq_lines = '0;
  logic        irq_valid;
  logic [4:0]  irq_id;
  logic        irq_ack = 1'b0;
  logic        nmi_req = 1'b0;
  logic        nmi_valid;
  logic        nmi_ack = 1'b0;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    bit       v;
    bit [4:0] id;
    string    tag;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  small_intc i_small_intc (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wstrb(bus_wstrb), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .irq_lines(irq_lines),
    .irq_valid(irq_valid), .irq_id(irq_id), .irq_ack(irq_ack),
    .nmi_req(nmi_req), .nmi_valid(nmi_valid), .nmi_ack(nmi_ack)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver side of the scoreboard: queue the expected channel state
  task automatic expect_out(bit v, bit [4:0] id, string tag);
    exp_t e;
    e.v = v; e.id = id; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor side: compare the channel when an item is queued
  initial begin
    forever begin
      exp_t e;
      wait (exp_q.size() != 0);
      #1;
      e = exp_q.pop_front();
      total++;
      if (irq_valid !== e.v || (e.v && irq_id !== e.id)) begin
        bad++;
        $display("FAIL %s actual=v%0b id%0d expected=v%0b id%0d",
                 e.tag, irq_valid, irq_id, e.v, e.id);
      end
    end
  end

  task automatic bus_write(logic [11:0] a, logic [31:0] d, logic [3:0] s = 4'hF);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wstrb = s; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wstrb = '0;
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    d = bus_rdata; e = bus_err;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic read_check(logic [11:0] a, logic [31:0] exp, string tag);
    logic [31:0] d;
    logic        e;
    bus_read(a, d, e);
    check(tag, d, exp);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d;
    logic        e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    expect_out(1'b0, 5'd0, "R1 no request after reset");
    check("R1 nmi idle", {31'b0, nmi_valid}, 32'h0);
    read_check(12'h100, 32'h0, "R1 enables zero");
    read_check(12'h200, 32'h0, "R1 pending zero");
    read_check(12'h41C, 32'h0, "R1 priorities zero");

    // R8 type word is reserved
    bus_read(12'h004, d, e);
    check("R8 type word error", {31'b0, e}, 32'h1);
    check("R8 type word data", d, 32'h0);
    bus_read(12'h100, d, e);
    check("R8 normal word no error", {31'b0, e}, 32'h0);

    // R10 control word
    read_check(12'hD0C, 32'hFA05_0000, "R10 control key");
    bus_write(12'hD0C, 32'h05FA_0700);
    read_check(12'hD0C, 32'hFA05_0000, "R10 group write ignored");

    // R4 priority truncation and byte lanes
    bus_write(12'h400, 32'hFFFF_FFFF, 4'b0010);
    read_check(12'h400, 32'h0000_C000, "R4 single lane, low bits zero");
    bus_write(12'h41C, 32'h4080_C0FF);
    read_check(12'h41C, 32'h4080_C0C0, "R4 full word truncated");

    // R3 enables
    bus_write(12'h100, 32'hC000_002A);
    read_check(12'h100, 32'hC000_002A, "R3 set enable");
    bus_write(12'h180, 32'h0);
    read_check(12'h180, 32'hC000_002A, "R3 clear-enable zeros ignored");
    expect_out(1'b0, 5'd0, "R5 nothing pending");

    // R3/R5/R6 pending and arbitration
    bus_write(12'h200, 32'h8000_0000);
    expect_out(1'b1, 5'd31, "R6 single pending shown next cycle");
    bus_write(12'h200, 32'h4000_0000);
    expect_out(1'b1, 5'd31, "R5 prio1 beats prio2");
    bus_write(12'h200, 32'h0000_0020);
    expect_out(1'b1, 5'd5, "R5 prio0 wins");
    bus_write(12'h200, 32'h0000_0008);
    expect_out(1'b1, 5'd3, "R5 tie to lowest number");

    // R2 edge on disabled line
    @(negedge clk); irq_lines[7] = 1'b1;
    @(negedge clk);
    expect_out(1'b1, 5'd3, "R5 disabled pending line ignored");
    read_check(12'h200, 32'hC000_00A8, "R2 rising edge latched");

    // R9 active window
    read_check(12'h300, 32'h0, "R9 active first word");
    read_check(12'h33C, 32'h0, "R9 active last word");

    // R7 acknowledge
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    expect_out(1'b1, 5'd5, "R7 ack retires shown line");
    read_check(12'h200, 32'hC000_00A0, "R7 pending after ack");

    // R3 clear pending
    bus_write(12'h280, 32'h0000_0020);
    expect_out(1'b1, 5'd31, "R3 clear pending");
    bus_write(12'h280, 32'h0);
    expect_out(1'b1, 5'd31, "R3 clear-pending zeros ignored");

    // R2 held level does not re-arm
    bus_write(12'h280, 32'h0000_0080);
    read_check(12'h200, 32'hC000_0000, "R2 held line not re-latched");
    @(negedge clk); irq_lines[7] = 1'b0;
    @(negedge clk); irq_lines[7] = 1'b1;
    @(negedge clk);
    read_check(12'h200, 32'hC000_0080, "R2 new edge latched");

    // R3 clear enable moves winner
    bus_write(12'h180, 32'h8000_0000);
    expect_out(1'b1, 5'd30, "R3 cleared enable drops line");
    read_check(12'h100, 32'h4000_002A, "R3 enable after clear");

    // R10 control write does not disturb selection
    bus_write(12'hD0C, 32'hFFFF_FFFF);
    expect_out(1'b1, 5'd30, "R10 control write no effect");

    // R11 NMI not blockable
    bus_write(12'h180, 32'hFFFF_FFFF);
    expect_out(1'b0, 5'd0, "R5 all disabled");
    @(negedge clk); nmi_req = 1'b1;
    @(negedge clk);
    #1 check("R11 nmi raised", {31'b0, nmi_valid}, 32'h1);
    @(negedge clk); nmi_ack = 1'b1;
    @(negedge clk); nmi_ack = 1'b0;
    #1 check("R11 nmi cleared by ack", {31'b0, nmi_valid}, 32'h0);

    wait (exp_q.size() == 0);
    #2;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule